// File: doc/BRIEF.md
# Road Window Hit Filter

This block sits in a tracking trigger between the cluster source and the track-fitting stage. For each event it first collects a list of track roads. Every road is a track identifier plus an inclusive coordinate window. Once the list is declared complete, the block accepts detector clusters one at a time. It converts each cluster coordinate from Gray code to binary and compares it against every stored road at the same time.

A cluster that lies inside no window is dropped. A cluster that lies inside one or more windows produces one output word per matching road, and each word carries that road's identifier. An end-of-event beat on the cluster stream is passed to the output as a marker after the final match of the event. Accepting that marker wipes the road list, so the next event starts empty.

The cluster input stays stalled until the road list is complete. An upstream buffer therefore holds any early clusters. Loads that exceed the road capacity are counted as an overflow.

Top module: `rwf_hit_filter`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `out_valid_o`, `clu_ready_o` and `overflow_o` are all low.
- R2: `clu_ready_o` stays low after reset, and after each end-of-event marker is accepted at the output, until `road_done_i` has been seen high at a clock edge.
- R3: `clu_gray_i` is Gray coded. Binary bit i is the XOR of Gray bits i and above. `out_coord_o` carries the binary value.
- R4: A stored road matches a cluster when its low bound ≤ coordinate ≤ its high bound. The comparison is unsigned and includes both ends.
- R5: A cluster that matches no stored road produces no output word.
- R6: A cluster that matches several roads produces one word per match. Slot index is load order since the last end of event, starting at 0. The words leave in ascending slot order, and `clu_ready_o` stays low until the last of them has been accepted.
- R7: `out_id_o` of a match word equals the identifier loaded with the matching road.
- R8: While `out_valid_o` is high and `out_ready_i` is low, the output word stays unchanged in the next cycle.
- R9: A cluster beat with `clu_eoe_i` high carries no coordinate. It yields one word with `out_eoe_o`=1, id 0 and coordinate 0, after every match word of the event. When that word is accepted, the stored roads, the completion state and `overflow_o` are all cleared.
- R10: The block holds at most MAX_ROADS (46) roads. Each later load in the same event is dropped and sets `overflow_o`. `overflow_o` stays high until the end-of-event clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| road_valid_i | input | 1 | One road load this cycle |
| road_id_i | input | ID_W | Track identifier of the road |
| road_lo_i | input | COORD_W | Inclusive lower window bound |
| road_hi_i | input | COORD_W | Inclusive upper window bound |
| road_done_i | input | 1 | Road list complete for this event |
| clu_valid_i | input | 1 | Cluster beat valid |
| clu_eoe_i | input | 1 | Beat is the end-of-event marker |
| clu_gray_i | input | COORD_W | Cluster coordinate, Gray coded |
| clu_ready_o | output | 1 | Cluster beat accepted when high with valid |
| out_valid_o | output | 1 | Output word valid |
| out_ready_i | input | 1 | Downstream accepts the word |
| out_eoe_o | output | 1 | Output word is the end-of-event marker |
| out_id_o | output | ID_W | Track identifier of the matching road |
| out_coord_o | output | COORD_W | Binary cluster coordinate |
| overflow_o | output | 1 | Sticky: a road load was dropped this event |

## Verification
The checker assumes three things about the inputs. Road loads never fall in the same cycle as the end-of-event handshake, because the clear takes priority and such a load would vanish. `road_done_i` is a plain level sampled at each edge. Input signals are never unknown after reset.

The stimulus respects this. It waits until every expected word, the end-of-event marker included, has left the output before it loads the next event's roads or pulses completion. Random backpressure on `out_ready_i` and random road sets of 0 to 46 entries are used, with one directed event that overfills the bank.

// File: rtl/rwf_pkg.sv
package rwf_pkg;
  localparam int unsigned DEF_ROADS   = 46;
  localparam int unsigned DEF_COORD_W = 16;
  localparam int unsigned DEF_ID_W    = 8;

  typedef enum logic [1:0] {
    OUT_IDLE  = 2'd0,
    OUT_MATCH = 2'd1,
    OUT_EOE   = 2'd2
  } out_state_e;
endpackage

// File: rtl/rwf_gray2bin.sv
module rwf_gray2bin #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] gray_i,
  output logic [W-1:0] bin_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign bin_o[i] = ^gray_i[W-1:i];
  end
endmodule

// File: rtl/rwf_window_cmp.sv
module rwf_window_cmp #(
  parameter int unsigned COORD_W = 16
) (
  input  logic               en_i,
  input  logic [COORD_W-1:0] lo_i,
  input  logic [COORD_W-1:0] hi_i,
  input  logic [COORD_W-1:0] coord_i,
  output logic               hit_o
);
  assign hit_o = en_i && (coord_i >= lo_i) && (coord_i <= hi_i);
endmodule

// File: rtl/rwf_road_bank.sv
module rwf_road_bank #(
  parameter int unsigned N       = 46,
  parameter int unsigned ID_W    = 8,
  parameter int unsigned COORD_W = 16,
  localparam int unsigned CNT_W  = $clog2(N + 1)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       load_i,
  input  logic [ID_W-1:0]            id_i,
  input  logic [COORD_W-1:0]         lo_i,
  input  logic [COORD_W-1:0]         hi_i,
  input  logic                       clear_i,
  output logic [N-1:0]               en_o,
  output logic [N-1:0][ID_W-1:0]     id_o,
  output logic [N-1:0][COORD_W-1:0]  lo_o,
  output logic [N-1:0][COORD_W-1:0]  hi_o,
  output logic                       ovf_o
);
  logic [N-1:0]              en_q;
  logic [N-1:0][ID_W-1:0]    id_q;
  logic [N-1:0][COORD_W-1:0] lo_q;
  logic [N-1:0][COORD_W-1:0] hi_q;
  logic [CNT_W-1:0]          cnt_q;
  logic                      ovf_q;
  logic                      full;
  logic                      wr_en;

  assign full  = (cnt_q == CNT_W'(N));
  assign wr_en = load_i && !clear_i && !full;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (clear_i) begin
      en_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (load_i) begin
      if (full) begin
        ovf_q <= 1'b1;
      end else begin
        en_q[cnt_q] <= 1'b1;
        cnt_q       <= cnt_q + CNT_W'(1);
      end
    end
  end

  // road payload needs no reset: en_q gates it
  always_ff @(posedge clk_i) begin
    if (wr_en) begin
      id_q[cnt_q] <= id_i;
      lo_q[cnt_q] <= lo_i;
      hi_q[cnt_q] <= hi_i;
    end
  end

  assign en_o  = en_q;
  assign id_o  = id_q;
  assign lo_o  = lo_q;
  assign hi_o  = hi_q;
  assign ovf_o = ovf_q;
endmodule

// File: rtl/rwf_match_ser.sv
module rwf_match_ser #(
  parameter int unsigned N      = 46,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [N-1:0]     mask_i,
  input  logic             pop_i,
  output logic             any_o,
  output logic             last_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [N-1:0] mask_q;
  logic [N-1:0] low_sel;
  logic [N-1:0] rest;

  // isolate lowest set bit
  assign low_sel = mask_q & (~mask_q + N'(1));
  assign rest    = mask_q & ~low_sel;
  assign any_o   = |mask_q;
  assign last_o  = ~|rest;

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (low_sel[i]) idx_o = IDX_W'(i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     mask_q <= '0;
    else if (load_i) mask_q <= mask_i;
    else if (pop_i)  mask_q <= rest;
  end
endmodule

// File: rtl/rwf_hit_filter.sv
module rwf_hit_filter
  import rwf_pkg::*;
#(
  parameter int unsigned MAX_ROADS = DEF_ROADS,
  parameter int unsigned COORD_W   = DEF_COORD_W,
  parameter int unsigned ID_W      = DEF_ID_W,
  localparam int unsigned IDX_W    = (MAX_ROADS > 1) ? $clog2(MAX_ROADS) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               road_valid_i,
  input  logic [ID_W-1:0]    road_id_i,
  input  logic [COORD_W-1:0] road_lo_i,
  input  logic [COORD_W-1:0] road_hi_i,
  input  logic               road_done_i,
  input  logic               clu_valid_i,
  input  logic               clu_eoe_i,
  input  logic [COORD_W-1:0] clu_gray_i,
  output logic               clu_ready_o,
  output logic               out_valid_o,
  input  logic               out_ready_i,
  output logic               out_eoe_o,
  output logic [ID_W-1:0]    out_id_o,
  output logic [COORD_W-1:0] out_coord_o,
  output logic               overflow_o
);
  out_state_e                        state_q;
  out_state_e                        state_d;
  logic                              done_q;
  logic [COORD_W-1:0]                coord_q;
  logic [COORD_W-1:0]                clu_bin;
  logic [MAX_ROADS-1:0]              road_en;
  logic [MAX_ROADS-1:0][ID_W-1:0]    road_id;
  logic [MAX_ROADS-1:0][COORD_W-1:0] road_lo;
  logic [MAX_ROADS-1:0][COORD_W-1:0] road_hi;
  logic [MAX_ROADS-1:0]              hits;
  logic                              accept;
  logic                              clu_load;
  logic                              pop;
  logic                              ser_any;
  logic                              ser_last;
  logic [IDX_W-1:0]                  ser_idx;
  logic                              eoe_hs;

  assign clu_ready_o = done_q && (state_q == OUT_IDLE);
  assign accept      = clu_valid_i && clu_ready_o;
  assign clu_load    = accept && !clu_eoe_i;
  assign pop         = (state_q == OUT_MATCH) && out_ready_i;
  assign eoe_hs      = (state_q == OUT_EOE) && out_ready_i;

  rwf_road_bank #(
    .N(MAX_ROADS), .ID_W(ID_W), .COORD_W(COORD_W)
  ) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (road_valid_i),
    .id_i    (road_id_i),
    .lo_i    (road_lo_i),
    .hi_i    (road_hi_i),
    .clear_i (eoe_hs),
    .en_o    (road_en),
    .id_o    (road_id),
    .lo_o    (road_lo),
    .hi_o    (road_hi),
    .ovf_o   (overflow_o)
  );

  rwf_gray2bin #(.W(COORD_W)) u_g2b (
    .gray_i (clu_gray_i),
    .bin_o  (clu_bin)
  );

  for (genvar r = 0; r < MAX_ROADS; r++) begin : g_cmp
    rwf_window_cmp #(.COORD_W(COORD_W)) u_cmp (
      .en_i    (road_en[r]),
      .lo_i    (road_lo[r]),
      .hi_i    (road_hi[r]),
      .coord_i (clu_bin),
      .hit_o   (hits[r])
    );
  end

  rwf_match_ser #(.N(MAX_ROADS)) u_ser (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (clu_load),
    .mask_i (hits),
    .pop_i  (pop),
    .any_o  (ser_any),
    .last_o (ser_last),
    .idx_o  (ser_idx)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      OUT_IDLE: begin
        if (accept && clu_eoe_i)     state_d = OUT_EOE;
        else if (clu_load && |hits)  state_d = OUT_MATCH;
      end
      OUT_MATCH: if (pop && ser_last) state_d = OUT_IDLE;
      OUT_EOE:   if (out_ready_i)     state_d = OUT_IDLE;
      default:                        state_d = OUT_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= OUT_IDLE;
      done_q  <= 1'b0;
      coord_q <= '0;
    end else begin
      state_q <= state_d;
      if (eoe_hs)           done_q <= 1'b0;
      else if (road_done_i) done_q <= 1'b1;
      if (clu_load) coord_q <= clu_bin;
    end
  end

  assign out_valid_o = (state_q == OUT_MATCH && ser_any) || (state_q == OUT_EOE);
  assign out_eoe_o   = (state_q == OUT_EOE);
  assign out_id_o    = out_eoe_o ? '0 : road_id[ser_idx];
  assign out_coord_o = out_eoe_o ? '0 : coord_q;
endmodule

// File: rtl/rwf_hit_filter_chk.sv
module rwf_hit_filter_chk #(
  parameter int unsigned MAX_ROADS = 46,
  parameter int unsigned COORD_W   = 16,
  parameter int unsigned ID_W      = 8,
  localparam int unsigned CNT_W    = $clog2(MAX_ROADS + 2)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               road_valid_i,
  input logic               road_done_i,
  input logic               clu_ready_o,
  input logic               out_valid_o,
  input logic               out_ready_i,
  input logic               out_eoe_o,
  input logic [ID_W-1:0]    out_id_o,
  input logic [COORD_W-1:0] out_coord_o,
  input logic               overflow_o
);
  logic             seen_done_q;
  logic [CNT_W-1:0] loads_q;
  logic             eoe_acc;

  assign eoe_acc = out_valid_o && out_ready_i && out_eoe_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_done_q <= 1'b0;
      loads_q     <= '0;
    end else begin
      if (eoe_acc)          seen_done_q <= 1'b0;
      else if (road_done_i) seen_done_q <= 1'b1;
      if (eoe_acc) loads_q <= '0;
      else if (road_valid_i && loads_q <= CNT_W'(MAX_ROADS)) loads_q <= loads_q + CNT_W'(1);
    end
  end

  // R2
  ready_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clu_ready_o |-> seen_done_q);

  // R6
  stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_eoe_o) |-> !clu_ready_o);

  // R8
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_id_o)
      && $stable(out_coord_o) && $stable(out_eoe_o)));

  // R9
  eoe_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoe_acc |=> (!overflow_o && !clu_ready_o));

  // R10
  ovf_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loads_q > CNT_W'(MAX_ROADS)) |-> overflow_o);

  // R10
  ovf_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loads_q <= CNT_W'(MAX_ROADS)) |-> !overflow_o);

  // R10
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overflow_o && !eoe_acc) |=> overflow_o);
endmodule

bind rwf_hit_filter rwf_hit_filter_chk #(
  .MAX_ROADS(MAX_ROADS), .COORD_W(COORD_W), .ID_W(ID_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .road_valid_i (road_valid_i),
  .road_done_i  (road_done_i),
  .clu_ready_o  (clu_ready_o),
  .out_valid_o  (out_valid_o),
  .out_ready_i  (out_ready_i),
  .out_eoe_o    (out_eoe_o),
  .out_id_o     (out_id_o),
  .out_coord_o  (out_coord_o),
  .overflow_o   (overflow_o)
);

// File: tb/rwf_hit_filter_tb.sv
module rwf_hit_filter_tb;
  localparam int N  = 46;
  localparam int CW = 16;
  localparam int IW = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          road_valid_i = 1'b0;
  logic [IW-1:0] road_id_i = '0;
  logic [CW-1:0] road_lo_i = '0;
  logic [CW-1:0] road_hi_i = '0;
  logic          road_done_i = 1'b0;
  logic          clu_valid_i = 1'b0;
  logic          clu_eoe_i = 1'b0;
  logic [CW-1:0] clu_gray_i = '0;
  logic          clu_ready_o;
  logic          out_valid_o;
  logic          out_ready_i = 1'b1;
  logic          out_eoe_o;
  logic [IW-1:0] out_id_o;
  logic [CW-1:0] out_coord_o;
  logic          overflow_o;

  always #4 clk_i = ~clk_i;

  rwf_hit_filter u_dut (.*);

  int checks = 0;
  int errors = 0;
  bit bp_en = 1'b0;

  // expected words: {eoe, id, coord}
  logic [IW+CW:0] exp_q[$];
  logic [IW-1:0]  m_id[N];
  logic [CW-1:0]  m_lo[N];
  logic [CW-1:0]  m_hi[N];
  int             m_cnt = 0;
  bit             m_ovf = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [CW-1:0] to_gray(input logic [CW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  // output monitor and backpressure
  bit             hold_pend = 1'b0;
  logic [IW+CW:0] hold_word;
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (hold_pend) begin
        chk(out_valid_o && {out_eoe_o, out_id_o, out_coord_o} == hold_word,
            "R8", "held word", {out_valid_o, out_eoe_o, out_id_o, out_coord_o},
            {1'b1, hold_word});
      end
      out_ready_i = bp_en ? ($urandom % 4 != 0) : 1'b1;
      hold_pend = out_valid_o && !out_ready_i;
      hold_word = {out_eoe_o, out_id_o, out_coord_o};
      if (out_valid_o && !out_eoe_o)
        chk(!clu_ready_o, "R6", "input stalls during matches", clu_ready_o, 0);
      if (out_valid_o && out_ready_i) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R5", "unexpected word", {out_eoe_o, out_id_o, out_coord_o}, 0);
        end else begin
          logic [IW+CW:0] e;
          e = exp_q.pop_front();
          chk(out_eoe_o == e[IW+CW], "R9", "eoe flag", out_eoe_o, e[IW+CW]);
          chk(out_id_o == e[IW+CW-1:CW], "R7", "road id (R6 order)", out_id_o, e[IW+CW-1:CW]);
          chk(out_coord_o == e[CW-1:0], "R3", "binary coordinate", out_coord_o, e[CW-1:0]);
        end
      end
    end
  end

  task automatic load_road(input logic [IW-1:0] id, input logic [CW-1:0] lo,
                           input logic [CW-1:0] hi);
    road_valid_i = 1'b1; road_id_i = id; road_lo_i = lo; road_hi_i = hi;
    if (m_cnt < N) begin
      m_id[m_cnt] = id; m_lo[m_cnt] = lo; m_hi[m_cnt] = hi; m_cnt++;
    end else begin
      m_ovf = 1'b1;
    end
    @(negedge clk_i);
    road_valid_i = 1'b0;
  endtask

  task automatic mark_done();
    road_done_i = 1'b1;
    @(negedge clk_i);
    road_done_i = 1'b0;
  endtask

  task automatic expect_cluster(input logic [CW-1:0] c);
    for (int i = 0; i < m_cnt; i++)
      if (m_lo[i] <= c && c <= m_hi[i]) exp_q.push_back({1'b0, m_id[i], c});
  endtask

  task automatic send_cluster(input logic [CW-1:0] c);
    expect_cluster(c);
    clu_valid_i = 1'b1; clu_eoe_i = 1'b0; clu_gray_i = to_gray(c);
    while (!clu_ready_o) @(negedge clk_i);
    @(negedge clk_i);
    clu_valid_i = 1'b0;
  endtask

  task automatic send_eoe();
    exp_q.push_back('0 | (1 << (IW + CW)));
    clu_valid_i = 1'b1; clu_eoe_i = 1'b1; clu_gray_i = $urandom;
    while (!clu_ready_o) @(negedge clk_i);
    @(negedge clk_i);
    clu_valid_i = 1'b0; clu_eoe_i = 1'b0;
    m_cnt = 0; m_ovf = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk_i);
    @(negedge clk_i);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    // R1
    chk(!out_valid_o && !clu_ready_o && !overflow_o, "R1", "in reset",
        {out_valid_o, clu_ready_o, overflow_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!out_valid_o && !clu_ready_o && !overflow_o, "R1", "after reset",
        {out_valid_o, clu_ready_o, overflow_o}, 0);

    // directed event: windows, boundaries, multi-match order
    load_road(8'h11, 16'd100, 16'd200);
    load_road(8'h22, 16'd150, 16'd150);
    load_road(8'h33, 16'd0,   16'd99);
    load_road(8'h44, 16'd200, 16'd300);
    // R2: cluster held back until road list complete
    expect_cluster(16'd150);
    clu_valid_i = 1'b1; clu_gray_i = to_gray(16'd150);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk_i);
      chk(!clu_ready_o && !out_valid_o, "R2", "blocked before done",
          {clu_ready_o, out_valid_o}, 0);
    end
    mark_done();
    while (!clu_ready_o) @(negedge clk_i);
    @(negedge clk_i);
    clu_valid_i = 1'b0;
    send_cluster(16'd100);    // R4 low edge
    send_cluster(16'd200);    // R4 high edge of road 0, low edge of road 3
    send_cluster(16'd99);
    send_cluster(16'd300);
    drain();
    // R5: no word for a miss
    send_cluster(16'd301);
    send_cluster(16'hFFFF);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk_i);
      chk(!out_valid_o, "R5", "miss discarded", out_valid_o, 0);
    end
    send_eoe();
    drain();
    // R9: completion cleared
    chk(!clu_ready_o, "R9", "done cleared by eoe", clu_ready_o, 0);

    // overflow event
    bp_en = 1'b1;
    for (int i = 0; i < N + 4; i++) begin
      if (i < N) load_road(IW'(i + 1), CW'(i * 1000), CW'(i * 1000 + 500));
      else       load_road(8'hEE, 16'd0, 16'hFFFF);
      chk(overflow_o == m_ovf, "R10", "overflow flag", overflow_o, m_ovf);
    end
    mark_done();
    send_cluster(16'd0);
    send_cluster(CW'(45 * 1000 + 500));   // last slot only
    send_cluster(16'd700);
    send_cluster(16'd2250);
    drain();
    chk(overflow_o, "R10", "overflow sticky", overflow_o, 1);
    send_eoe();
    drain();
    chk(!overflow_o, "R9", "overflow cleared by eoe", overflow_o, 0);

    // random events with overlapping windows
    for (int ev = 0; ev < 40; ev++) begin
      int nr;
      nr = $urandom % (N + 1);
      for (int i = 0; i < nr; i++) begin
        logic [CW-1:0] lo, hi;
        lo = CW'($urandom % 8000);
        hi = lo + CW'($urandom % 1500);
        load_road(IW'($urandom), lo, hi);
      end
      mark_done();
      for (int c = 0; c < 30; c++) begin
        logic [CW-1:0] x;
        if ($urandom % 8 == 0) x = CW'($urandom);
        else x = CW'($urandom % 9600);
        send_cluster(x);
      end
      send_eoe();
      drain();
      chk(!clu_ready_o && !overflow_o, "R9", "event cleared",
          {clu_ready_o, overflow_o}, 0);
    end

    chk(exp_q.size() == 0, "R6", "all expected words seen", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule